// File: doc/BRIEF.md
# Standby Power Domain Sequencer

This controller takes a chip with gated core power domains into standby sleep and brings it back out. There are three gated domains: a switchable peripheral domain, a RAM domain and a PLL clock domain. There are also two supplies: the main core regulator and an additional regulator that feeds the PLL domain. When software asks for sleep, the controller decides which domains stay powered. Its inputs for that decision are the peripherals' run-in-standby flags, the PLL clock request lines, a configuration bit that keeps the PLL regulator on, and whether any generic clock is still busy. It then gates everything else.

On a wake interrupt the controller powers the RAM domain and the peripheral domain back up and returns the main regulator to full-power mode. If the CPU runs from a PLL clock, it also restarts the PLL regulator and the PLL domain. The CPU is released only after each domain that was actually switched off has reported ready. Domains that stayed on are not waited for. A saturating counter records how many cycles the wake power-up took. Regulator and domain readiness arrive as handshake inputs.

The sequence has five states:
- ACTIVE: normal run, CPU released.
- ENTER_STANDBY: one cycle, the gating plan is captured.
- STANDBY: gated.
- WAKE_POWERUP: waiting on handshakes.
- RELEASE: one cycle, CPU released.

The transitions are:
- ACTIVE→ENTER_STANDBY on a sleep request.
- ENTER_STANDBY→STANDBY when no wake is present.
- ENTER_STANDBY→WAKE_POWERUP when a wake arrives during entry (abort).
- STANDBY→WAKE_POWERUP on a wake.
- WAKE_POWERUP→RELEASE once the required handshakes are all high.
- RELEASE→ACTIVE unconditionally.

An asynchronous active-low reset returns the controller to ACTIVE.

Top module: `stby_pwr_seq`

## Requirements
- R1: After reset the controller is in ACTIVE. In that state `cpu_release`=1, all three domain enables=1, `pll_reg_en`=1, `main_reg_lp`=0 and `wake_cycles`=0.
- R2: A `sleep_req` sampled in ACTIVE moves to ENTER_STANDBY at the next edge. There `cpu_release`=0 and all domains stay enabled. The following edge enters STANDBY, where `ram_dom_en`=0 and `cpu_release`=0.
- R3: In STANDBY, `sw_dom_en`=1 exactly when at least one `run_stby` bit was 1 during ENTER_STANDBY.
- R4: In STANDBY, `pll_dom_en` and `pll_reg_en` are both 1 when `pll_keep_on` or any `pll_clk_req` bit was 1 during ENTER_STANDBY; otherwise both are 0.
- R5: In STANDBY, `main_reg_lp`=1 exactly when `gclk_busy` was 0 during ENTER_STANDBY.
- R6: A nonzero `wake_irq` in STANDBY moves to WAKE_POWERUP at the next edge. There `ram_dom_en`=1, `sw_dom_en`=1, `main_reg_lp`=0 and `cpu_release`=0. `pll_dom_en`=`pll_reg_en`=1 when the PLL was kept on or `cpu_on_pll`=1.
- R7: WAKE_POWERUP moves to RELEASE one edge after all required handshakes are high. The required set is:
  - `ram_dom_ready`;
  - `sw_dom_ready`, if the peripheral domain was off;
  - `main_reg_ready`, if the main regulator was in low-power mode;
  - both `pll_dom_ready` and `pll_reg_ready`, if the PLL was off and `cpu_on_pll`=1.

  RELEASE holds `cpu_release`=1 for one cycle and then returns to ACTIVE.
- R8: `wake_irq` has no effect in ACTIVE: `cpu_release` stays 1 and `wake_cycles` keeps its value.
- R9: A nonzero `wake_irq` during ENTER_STANDBY aborts entry and goes to WAKE_POWERUP. Since nothing was switched off, no handshake is awaited: RELEASE follows one edge later and `wake_cycles`=1.
- R10: `wake_cycles` clears when WAKE_POWERUP is entered and counts the cycles spent in it. It saturates at 2^LAT_W−1 and holds its value from RELEASE until the next wake.
- R11: A domain kept on during standby imposes no wait: its ready inputs may stay low without delaying release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Request to enter standby |
| run_stby | input | NUM_PERIPH | Per-peripheral run-in-standby flags |
| pll_keep_on | input | 1 | Keep PLL regulator and domain on in standby |
| pll_clk_req | input | NUM_PLL_REQ | PLL clock request lines |
| gclk_busy | input | 1 | A generic clock is in use |
| wake_irq | input | NUM_WAKE | Wake interrupt lines |
| cpu_on_pll | input | 1 | CPU clock is sourced from the PLL domain |
| ram_dom_ready | input | 1 | RAM domain active handshake |
| sw_dom_ready | input | 1 | Peripheral domain active handshake |
| pll_dom_ready | input | 1 | PLL domain active handshake |
| main_reg_ready | input | 1 | Main regulator ready handshake |
| pll_reg_ready | input | 1 | PLL regulator ready handshake |
| sw_dom_en | output | 1 | Peripheral domain enable |
| ram_dom_en | output | 1 | RAM domain enable |
| pll_dom_en | output | 1 | PLL domain enable |
| pll_reg_en | output | 1 | PLL regulator enable |
| main_reg_lp | output | 1 | Main regulator low-power mode |
| cpu_release | output | 1 | CPU may run |
| wake_cycles | output | LAT_W | Saturating wake-up latency count |

## Verification
Each result is due at a fixed number of edges after its stimulus:
- The ENTER_STANDBY outputs appear one edge after `sleep_req` is sampled, and the STANDBY outputs one edge after that.
- The WAKE_POWERUP outputs appear one edge after `wake_irq`.
- `cpu_release` rises one edge after the last required handshake goes high.
- `wake_cycles` equals the number of WAKE_POWERUP cycles, saturated.

The bench drives every input just after a falling edge and reads the outputs at the next falling edge, so each check lands exactly one registered step after its stimulus. The sweep covers all 256 combinations of the gating inputs, with a handshake delay that varies per combination. Only the handshakes the requirements call for are raised, so a late, early or unneeded wait shows up as a wrong `cpu_release` or `wake_cycles`.

// File: rtl/stby_pkg.sv
package stby_pkg;

    typedef enum logic [2:0] {
        ST_ACTIVE  = 3'd0,
        ST_ENTER   = 3'd1,
        ST_STBY    = 3'd2,
        ST_WAKE    = 3'd3,
        ST_RELEASE = 3'd4
    } seq_state_t;

    // What is switched off for the current standby episode
    typedef struct packed {
        logic off_sw;
        logic off_ram;
        logic off_pll;
        logic main_lp;
    } gate_plan_t;

endpackage

// File: rtl/stby_gate_plan.sv
module stby_gate_plan
    import stby_pkg::*;
#(
    parameter int NUM_PERIPH  = 4,
    parameter int NUM_PLL_REQ = 2
) (
    input  logic [NUM_PERIPH-1:0]  run_stby,
    input  logic                   pll_keep_on,
    input  logic [NUM_PLL_REQ-1:0] pll_clk_req,
    input  logic                   gclk_busy,
    output gate_plan_t             plan
);

    always_comb begin
        plan.off_sw  = ~(|run_stby);
        plan.off_ram = 1'b1;
        plan.off_pll = ~pll_keep_on & ~(|pll_clk_req);
        plan.main_lp = ~gclk_busy;
    end

endmodule

// File: rtl/stby_release_gate.sv
module stby_release_gate
    import stby_pkg::*;
(
    input  gate_plan_t plan,
    input  logic       cpu_on_pll,
    input  logic       ram_dom_ready,
    input  logic       sw_dom_ready,
    input  logic       pll_dom_ready,
    input  logic       main_reg_ready,
    input  logic       pll_reg_ready,
    output logic       all_ok
);

    logic ram_ok, sw_ok, main_ok, pll_ok;

    always_comb begin
        ram_ok  = ~plan.off_ram | ram_dom_ready;
        sw_ok   = ~plan.off_sw  | sw_dom_ready;
        main_ok = ~plan.main_lp | main_reg_ready;
        pll_ok  = ~(plan.off_pll & cpu_on_pll) | (pll_dom_ready & pll_reg_ready);
        all_ok  = ram_ok & sw_ok & main_ok & pll_ok;
    end

endmodule

// File: rtl/stby_wake_ctr.sv
module stby_wake_ctr #(
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    output logic [LAT_W-1:0] count
);

    localparam logic [LAT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (run && count != CNT_MAX) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/stby_pwr_seq.sv
module stby_pwr_seq
    import stby_pkg::*;
#(
    parameter int NUM_PERIPH  = 4,
    parameter int NUM_PLL_REQ = 2,
    parameter int NUM_WAKE    = 4,
    parameter int LAT_W       = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sleep_req,
    input  logic [NUM_PERIPH-1:0]  run_stby,
    input  logic                   pll_keep_on,
    input  logic [NUM_PLL_REQ-1:0] pll_clk_req,
    input  logic                   gclk_busy,
    input  logic [NUM_WAKE-1:0]    wake_irq,
    input  logic                   cpu_on_pll,
    input  logic                   ram_dom_ready,
    input  logic                   sw_dom_ready,
    input  logic                   pll_dom_ready,
    input  logic                   main_reg_ready,
    input  logic                   pll_reg_ready,
    output logic                   sw_dom_en,
    output logic                   ram_dom_en,
    output logic                   pll_dom_en,
    output logic                   pll_reg_en,
    output logic                   main_reg_lp,
    output logic                   cpu_release,
    output logic [LAT_W-1:0]       wake_cycles
);

    seq_state_t state, nxt;
    gate_plan_t plan_d, plan_q;
    logic       wake_any, ready_all;

    assign wake_any = |wake_irq;

    stby_gate_plan #(
        .NUM_PERIPH (NUM_PERIPH),
        .NUM_PLL_REQ(NUM_PLL_REQ)
    ) u_plan (
        .run_stby   (run_stby),
        .pll_keep_on(pll_keep_on),
        .pll_clk_req(pll_clk_req),
        .gclk_busy  (gclk_busy),
        .plan       (plan_d)
    );

    stby_release_gate u_gate (
        .plan          (plan_q),
        .cpu_on_pll    (cpu_on_pll),
        .ram_dom_ready (ram_dom_ready),
        .sw_dom_ready  (sw_dom_ready),
        .pll_dom_ready (pll_dom_ready),
        .main_reg_ready(main_reg_ready),
        .pll_reg_ready (pll_reg_ready),
        .all_ok        (ready_all)
    );

    stby_wake_ctr #(.LAT_W(LAT_W)) u_ctr (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(nxt == ST_WAKE && state != ST_WAKE),
        .run  (state == ST_WAKE),
        .count(wake_cycles)
    );

    // State register and captured gating plan
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_ACTIVE;
            plan_q <= '0;
        end else begin
            state <= nxt;
            if (state == ST_ENTER && nxt == ST_STBY) begin
                plan_q <= plan_d;
            end else if (state == ST_RELEASE) begin
                plan_q <= '0;
            end
        end
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_ACTIVE:  if (sleep_req) nxt = ST_ENTER;
            ST_ENTER:   nxt = wake_any ? ST_WAKE : ST_STBY;
            ST_STBY:    if (wake_any) nxt = ST_WAKE;
            ST_WAKE:    if (ready_all) nxt = ST_RELEASE;
            ST_RELEASE: nxt = ST_ACTIVE;
            default:    nxt = ST_ACTIVE;
        endcase
    end

    // Outputs
    always_comb begin
        sw_dom_en   = 1'b1;
        ram_dom_en  = 1'b1;
        pll_dom_en  = 1'b1;
        pll_reg_en  = 1'b1;
        main_reg_lp = 1'b0;
        cpu_release = 1'b0;
        unique case (state)
            ST_ACTIVE: cpu_release = 1'b1;
            ST_ENTER:  cpu_release = 1'b0;
            ST_STBY: begin
                sw_dom_en   = ~plan_q.off_sw;
                ram_dom_en  = ~plan_q.off_ram;
                pll_dom_en  = ~plan_q.off_pll;
                pll_reg_en  = ~plan_q.off_pll;
                main_reg_lp = plan_q.main_lp;
            end
            ST_WAKE, ST_RELEASE: begin
                pll_dom_en  = ~plan_q.off_pll | cpu_on_pll;
                pll_reg_en  = ~plan_q.off_pll | cpu_on_pll;
                cpu_release = (state == ST_RELEASE);
            end
            default: cpu_release = 1'b0;
        endcase
    end

    AST_RAM_GATED_ONLY_STBY: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_dom_en |-> state == ST_STBY); // R2

    AST_PLL_KEPT_HAS_REG: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STBY && pll_dom_en) |-> pll_reg_en); // R4

    AST_WAKE_FULL_POWER: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAKE) |-> (!main_reg_lp && ram_dom_en && !cpu_release)); // R6

    AST_RELEASE_AFTER_RAM: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RELEASE && plan_q.off_ram) |-> $past(ram_dom_ready)); // R7

    AST_ACTIVE_IGNORES_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACTIVE && !sleep_req) |=> (state == ST_ACTIVE)); // R8

    AST_ENTRY_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ENTER && wake_any) |=> (state == ST_WAKE)); // R9

    AST_COUNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RELEASE) |=> $stable(wake_cycles)); // R10

endmodule

// File: tb/stby_pwr_seq_test.sv
module stby_pwr_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 3;
    localparam int NR = 2;
    localparam int NW = 2;
    localparam int LW = 4;
    localparam int SAT = (1 << LW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_req = 1'b0;
    logic [NP-1:0] run_stby = '0;
    logic pll_keep_on = 1'b0;
    logic [NR-1:0] pll_clk_req = '0;
    logic gclk_busy = 1'b0;
    logic [NW-1:0] wake_irq = '0;
    logic cpu_on_pll = 1'b0;
    logic ram_dom_ready = 1'b0;
    logic sw_dom_ready = 1'b0;
    logic pll_dom_ready = 1'b0;
    logic main_reg_ready = 1'b0;
    logic pll_reg_ready = 1'b0;
    logic sw_dom_en, ram_dom_en, pll_dom_en, pll_reg_en, main_reg_lp, cpu_release;
    logic [LW-1:0] wake_cycles;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    stby_pwr_seq #(
        .NUM_PERIPH(NP), .NUM_PLL_REQ(NR), .NUM_WAKE(NW), .LAT_W(LW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .run_stby(run_stby),
        .pll_keep_on(pll_keep_on), .pll_clk_req(pll_clk_req), .gclk_busy(gclk_busy),
        .wake_irq(wake_irq), .cpu_on_pll(cpu_on_pll), .ram_dom_ready(ram_dom_ready),
        .sw_dom_ready(sw_dom_ready), .pll_dom_ready(pll_dom_ready),
        .main_reg_ready(main_reg_ready), .pll_reg_ready(pll_reg_ready),
        .sw_dom_en(sw_dom_en), .ram_dom_en(ram_dom_en), .pll_dom_en(pll_dom_en),
        .pll_reg_en(pll_reg_en), .main_reg_lp(main_reg_lp), .cpu_release(cpu_release),
        .wake_cycles(wake_cycles)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    task automatic all_ready(input logic v);
        ram_dom_ready = v; sw_dom_ready = v; pll_dom_ready = v;
        main_reg_ready = v; pll_reg_ready = v;
    endtask

    // Bits encode {sw, ram, pll_dom, pll_reg, lp, release}
    function automatic int outs();
        return {26'd0, sw_dom_en, ram_dom_en, pll_dom_en, pll_reg_en, main_reg_lp, cpu_release};
    endfunction

    initial begin
        #(CLK_PERIOD * 2 + 1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 outputs after reset", outs(), 6'b111101);
        check("R1 count after reset", int'(wake_cycles), 0);

        // R8: wake in ACTIVE has no effect
        wake_irq = 2'b11;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R8 release held under wake", outs(), 6'b111101);
        end
        wake_irq = '0;
        check("R8 count unchanged", int'(wake_cycles), 0);

        // R9: abort during entry, nothing awaited
        all_ready(1'b0);
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        wake_irq = 2'b01;
        @(negedge clk);
        wake_irq = '0;
        check("R9 wake state after abort", outs(), 6'b111100);
        @(negedge clk);
        check("R9 release one edge later", int'(cpu_release), 1);
        check("R9 latency", int'(wake_cycles), 1);
        @(negedge clk);
        check("R9 back in ACTIVE", outs(), 6'b111101);

        // Sweep over all gating inputs
        for (int cfg = 0; cfg < 256; cfg++) begin
            automatic logic off_sw, off_pll, lp, cpu, pll_on_wake;
            automatic int d;
            automatic int exp_lat;
            run_stby    = cfg[2:0];
            pll_keep_on = cfg[3];
            pll_clk_req = cfg[5:4];
            gclk_busy   = cfg[6];
            cpu_on_pll  = cfg[7];
            off_sw  = (cfg[2:0] == 0);
            off_pll = !cfg[3] && (cfg[5:4] == 0);
            lp      = !cfg[6];
            cpu     = cfg[7];
            pll_on_wake = !off_pll || cpu;
            d = cfg % 19;
            exp_lat = (d + 1 > SAT) ? SAT : d + 1;
            all_ready(1'b0);
            sleep_req = 1'b1;
            @(negedge clk);
            sleep_req = 1'b0;
            check("R2 entry outputs", outs(), 6'b111100);
            @(negedge clk);
            check("R3 sw domain in standby", int'(sw_dom_en), int'(!off_sw));
            check("R2 ram gated in standby", int'(ram_dom_en), 0);
            check("R4 pll domain in standby", int'(pll_dom_en), int'(!off_pll));
            check("R4 pll regulator in standby", int'(pll_reg_en), int'(!off_pll));
            check("R5 main regulator mode", int'(main_reg_lp), int'(lp));
            check("R2 cpu held", int'(cpu_release), 0);
            wake_irq = cfg[0] ? 2'b01 : 2'b10;
            @(negedge clk);
            wake_irq = '0;
            check("R6 wake outputs", outs(),
                  int'({1'b1, 1'b1, pll_on_wake, pll_on_wake, 1'b0, 1'b0}));
            for (int k = 0; k < d; k++) begin
                @(negedge clk);
                check("R7 no release before handshakes", int'(cpu_release), 0);
            end
            // Raise only the required handshakes (R11: kept domains stay low)
            ram_dom_ready  = 1'b1;
            sw_dom_ready   = off_sw;
            main_reg_ready = lp;
            pll_dom_ready  = off_pll && cpu;
            pll_reg_ready  = off_pll && cpu;
            @(negedge clk);
            check("R7 R11 release after required handshakes", int'(cpu_release), 1);
            if (!cpu_release) begin
                all_ready(1'b1);
                for (int w = 0; w < 40 && !cpu_release; w++) @(negedge clk);
            end
            check("R10 latency count", int'(wake_cycles), exp_lat);
            all_ready(1'b0);
            @(negedge clk);
            check("R1 back to ACTIVE", outs(), 6'b111101);
            check("R10 count held", int'(wake_cycles), exp_lat);
        end

        finish_run();
    end

endmodule